// File: doc/BRIEF.md
# BCD Carry-Chain Adder-Subtractor

This block adds or subtracts two packed decimal operands of `DIGITS` BCD digits each, with no clock. Both operands are read as ten's complement decimal integers. A mode input selects addition or subtraction. In subtract mode every digit of the second operand is replaced by its nine's complement inside the digit logic, and the carry into the lowest digit is forced to one, so the block adds the negated operand.

Each digit position has four parts. A cell forms a decimal propagate flag (the digit sum is exactly 9) and a decimal generate flag (the digit sum is above 9). A one-bit mux cell passes the incoming carry when propagate is set and otherwise takes generate. A correction stage forms the binary digit sum plus the incoming carry and adds 6 modulo 16 when the outgoing carry is set. The block also gives the decimal carry out of the top digit and a signed overflow flag.

Top module: `bcd_addsub`

## Requirements
- R1: With `sub_i`=0, `sum_o` equals (X + Y + `cin_i`) mod 10^DIGITS, where X and Y are the unsigned decimal values of `x_i` and `y_i`.
- R2: With `sub_i`=1, `sum_o` equals (X − Y) mod 10^DIGITS, and `cin_i` has no effect on any output.
- R3: `cout_o` is 1 exactly when X + Y + `cin_i` ≥ 10^DIGITS in add mode, and exactly when X ≥ Y in subtract mode.
- R4: `ovf_o` is 1 exactly when the signed result (X ± Y, plus `cin_i` in add mode) lies outside [−10^DIGITS/2, 10^DIGITS/2), with operands read as ten's complement.
- R5: Every digit of `sum_o` is in 0..9 whenever every input digit is in 0..9.
- R6: A carry travels through any run of digit positions whose digit sum is exactly 9, up to the full width. For example, 99999999 + 0 with carry-in 1 gives 00000000 with `cout_o`=1.
- R7: Subtracting an operand from itself gives zero, `cout_o`=1 and `ovf_o`=0.
- R8: Digit k sits at bits [4k+3:4k] of each vector, with digit 0 least significant. An operand is negative exactly when its top digit is 5 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 4*DIGITS | First operand, packed BCD |
| y_i | input | 4*DIGITS | Second operand, packed BCD |
| sub_i | input | 1 | 1 selects X − Y, 0 selects X + Y |
| cin_i | input | 1 | Carry into digit 0 in add mode |
| sum_o | output | 4*DIGITS | Packed BCD result |
| cout_o | output | 1 | Decimal carry out of the top digit |
| ovf_o | output | 1 | Ten's complement signed overflow |

## Verification
The hardest case to reach is a carry that must cross every digit through propagate cells alone. Random digits almost never give a digit sum of exactly 9 in every position. The stimulus therefore builds such runs on purpose: all-9s operands against zero with a carry-in, alternating 5/4 and 9/0 digit patterns whose digit sums are all 9, and subtraction of an operand from itself. The sign boundary at a top digit of 5 is driven from both sides, with operands just inside and just outside the signed range.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DIG_W = 4;
  typedef logic [DIG_W-1:0] bcd_digit_t;

  // Nine's complement of a valid BCD digit.
  function automatic bcd_digit_t nines_comp(input bcd_digit_t d);
    return {~d[3] & ~d[2] & ~d[1], d[2] ^ d[1], d[1], ~d[0]};
  endfunction

  // Ten's complement sign class from the top digit.
  function automatic logic digit_neg(input bcd_digit_t d);
    return (d >= 4'd5);
  endfunction
endpackage

// File: rtl/bcd_digit_pg.sv
module bcd_digit_pg
  import bcd_pkg::*;
#(
  parameter bit DIRECT_PG = 1'b1
) (
  input  bcd_digit_t x_d_i,
  input  bcd_digit_t y_d_i,
  input  logic       sub_i,
  output bcd_digit_t w_d_o,
  output logic       p_o,
  output logic       g_o
);
  bcd_digit_t w_d;

  assign w_d   = sub_i ? nines_comp(y_d_i) : y_d_i;
  assign w_d_o = w_d;

  generate
    if (DIRECT_PG) begin : g_direct
      // Sum of the three upper bits decides; bit 0 refines the boundary.
      logic [3:0] half_sum;
      logic       pp, gg;
      assign half_sum = {1'b0, x_d_i[3:1]} + {1'b0, w_d[3:1]};
      assign pp  = (half_sum == 4'd4);
      assign gg  = (half_sum >= 4'd5);
      assign p_o = (x_d_i[0] ^ w_d[0]) & pp;
      assign g_o = gg | (pp & x_d_i[0] & w_d[0]);
    end else begin : g_by_sum
      logic [4:0] dsum;
      assign dsum = {1'b0, x_d_i} + {1'b0, w_d};
      assign p_o  = (dsum == 5'd9);
      assign g_o  = (dsum > 5'd9);
    end
  endgenerate
endmodule

// File: rtl/bcd_carry_cell.sv
module bcd_carry_cell (
  input  logic p_i,
  input  logic g_i,
  input  logic c_i,
  output logic c_o
);
  assign c_o = p_i ? c_i : g_i;
endmodule

// File: rtl/bcd_digit_fix.sv
module bcd_digit_fix
  import bcd_pkg::*;
(
  input  bcd_digit_t x_d_i,
  input  bcd_digit_t w_d_i,
  input  logic       c_i,
  input  logic       c_o,
  output bcd_digit_t z_d_o
);
  logic [4:0] bin_sum;

  assign bin_sum = {1'b0, x_d_i} + {1'b0, w_d_i} + {4'b0, c_i};
  // Add 6 modulo 16 when this digit hands a carry upward.
  assign z_d_o   = bin_sum[3:0] + (c_o ? 4'd6 : 4'd0);
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_pkg::*;
#(
  parameter int unsigned DIGITS    = 8,
  parameter bit          DIRECT_PG = 1'b1
) (
  input  logic [DIG_W*DIGITS-1:0] x_i,
  input  logic [DIG_W*DIGITS-1:0] y_i,
  input  logic                    sub_i,
  input  logic                    cin_i,
  output logic [DIG_W*DIGITS-1:0] sum_o,
  output logic                    cout_o,
  output logic                    ovf_o
);
  localparam int unsigned VEC_W = DIG_W * DIGITS;
  localparam int unsigned TOP   = VEC_W - DIG_W;

  logic [DIGITS:0]   carry;
  logic [DIGITS-1:0] prop, gen;
  logic [VEC_W-1:0]  w_vec;
  logic              x_neg, w_neg, z_neg;

  // Subtraction adds nine's complement plus one; cin_i is not used then.
  assign carry[0] = sub_i | cin_i;

  generate
    for (genvar k = 0; k < DIGITS; k++) begin : g_digit
      bcd_digit_pg #(.DIRECT_PG(DIRECT_PG)) i_pg (
        .x_d_i (x_i[DIG_W*k +: DIG_W]),
        .y_d_i (y_i[DIG_W*k +: DIG_W]),
        .sub_i (sub_i),
        .w_d_o (w_vec[DIG_W*k +: DIG_W]),
        .p_o   (prop[k]),
        .g_o   (gen[k])
      );

      bcd_carry_cell i_cy (
        .p_i (prop[k]),
        .g_i (gen[k]),
        .c_i (carry[k]),
        .c_o (carry[k+1])
      );

      bcd_digit_fix i_fix (
        .x_d_i (x_i[DIG_W*k +: DIG_W]),
        .w_d_i (w_vec[DIG_W*k +: DIG_W]),
        .c_i   (carry[k]),
        .c_o   (carry[k+1]),
        .z_d_o (sum_o[DIG_W*k +: DIG_W])
      );
    end
  endgenerate

  assign cout_o = carry[DIGITS];

  assign x_neg = digit_neg(x_i[TOP +: DIG_W]);
  assign w_neg = digit_neg(w_vec[TOP +: DIG_W]);
  assign z_neg = digit_neg(sum_o[TOP +: DIG_W]);
  assign ovf_o = (x_neg == w_neg) & (z_neg != x_neg);
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk
  import bcd_pkg::*;
#(
  parameter int unsigned DIGITS = 8
) (
  input logic [DIG_W*DIGITS-1:0] x_i,
  input logic [DIG_W*DIGITS-1:0] y_i,
  input logic                    sub_i,
  input logic                    cin_i,
  input logic [DIG_W*DIGITS-1:0] sum_o,
  input logic                    cout_o,
  input logic                    ovf_o,
  input logic [DIGITS-1:0]       prop,
  input logic [DIGITS-1:0]       gen
);
  localparam int unsigned TOP = DIG_W * DIGITS - DIG_W;

  function automatic logic all_bcd(input logic [DIG_W*DIGITS-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++)
      if (v[DIG_W*k +: DIG_W] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  logic chk_en;
  assign chk_en = !$isunknown({x_i, y_i, sub_i, cin_i}) && all_bcd(x_i) && all_bcd(y_i);

  always_comb begin
    if (chk_en) begin
      p_digit_valid_r5: assert (all_bcd(sum_o))
        else $error("R5 result digit above 9");
      p_pg_excl_r6: assert ((prop & gen) == '0)
        else $error("R6 propagate and generate both set");
      p_ovf_sign_r4: assert (!ovf_o ||
                             (digit_neg(sum_o[TOP +: DIG_W]) != digit_neg(x_i[TOP +: DIG_W])))
        else $error("R4 overflow without sign change");
      if (!sub_i && !cin_i && y_i == '0) begin
        p_add_zero_r1: assert (sum_o == x_i && !cout_o && !ovf_o)
          else $error("R1 adding zero changed operand");
      end
      if (sub_i && x_i == y_i) begin
        p_self_sub_r7: assert (sum_o == '0 && cout_o && !ovf_o)
          else $error("R7 self subtraction not zero");
      end
    end
  end
endmodule

bind bcd_addsub bcd_addsub_chk #(.DIGITS(DIGITS)) i_chk (
  .x_i    (x_i),
  .y_i    (y_i),
  .sub_i  (sub_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .ovf_o  (ovf_o),
  .prop   (prop),
  .gen    (gen)
);

// File: tb/test_bcd_addsub.sv
`timescale 1ns/1ps
module test_bcd_addsub;
  localparam int unsigned DIGITS = 8;
  localparam int unsigned VEC_W  = 4 * DIGITS;
  localparam int unsigned WDOG   = 200000;

  typedef struct {
    logic [VEC_W-1:0] sum;
    logic             cout;
    logic             ovf;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [VEC_W-1:0] x_i = '0, y_i = '0;
  logic sub_i = 1'b0, cin_i = 1'b0;
  logic [VEC_W-1:0] sum_o;
  logic cout_o, ovf_o;

  int n_cmp = 0, n_bad = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  bcd_addsub #(.DIGITS(DIGITS)) i_bcd_addsub (
    .x_i (x_i), .y_i (y_i), .sub_i (sub_i), .cin_i (cin_i),
    .sum_o (sum_o), .cout_o (cout_o), .ovf_o (ovf_o)
  );

  function automatic longint pow10n();
    longint p = 1;
    for (int k = 0; k < DIGITS; k++) p = p * 10;
    return p;
  endfunction

  function automatic longint to_int(input logic [VEC_W-1:0] v);
    longint r = 0;
    for (int k = DIGITS - 1; k >= 0; k--) r = r * 10 + longint'(v[4*k +: 4]);
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] to_bcd(input longint n);
    logic [VEC_W-1:0] v = '0;
    longint t = n;
    for (int k = 0; k < DIGITS; k++) begin
      v[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] rand_bcd();
    logic [VEC_W-1:0] v;
    for (int k = 0; k < DIGITS; k++) v[4*k +: 4] = 4'($urandom_range(9));
    return v;
  endfunction

  function automatic logic all_bcd(input logic [VEC_W-1:0] v);
    for (int k = 0; k < DIGITS; k++) if (v[4*k +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: apply stimulus, push the expected outcome from the integer model.
  task automatic drive(input logic [VEC_W-1:0] x, input logic [VEC_W-1:0] y,
                       input logic sub, input logic cin, input string tag);
    exp_t e;
    longint p = pow10n();
    longint xv = to_int(x), yv = to_int(y);
    longint tot, sx, sy, sv;
    @(negedge clk);
    x_i = x; y_i = y; sub_i = sub; cin_i = cin;
    tot = sub ? (xv + (p - 1 - yv) + 1) : (xv + yv + longint'(cin));
    sx = (xv >= p / 2) ? xv - p : xv;
    sy = (yv >= p / 2) ? yv - p : yv;
    sv = sub ? (sx - sy) : (sx + sy + longint'(cin));
    e.sum  = to_bcd(tot % p);
    e.cout = (tot >= p);
    e.ovf  = (sv < -(p / 2)) || (sv >= p / 2);
    e.tag  = tag;
    q.push_back(e);
  endtask

  // Monitor: compare at the posedge after each negedge drive.
  always @(posedge clk) begin
    if (rst_ni && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "sum", longint'(sum_o), longint'(e.sum));
      check("R3", "cout", longint'(cout_o), longint'(e.cout));
      check("R4", "ovf", longint'(ovf_o), longint'(e.ovf));
      check("R5", "digits valid", longint'(all_bcd(sum_o)), 1);
    end
  end

  bit done = 1'b0;

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // Reset/idle state: zero operands give zero outputs (R1).
    check("R1", "idle sum", longint'(sum_o), 0);
    check("R1", "idle cout", longint'(cout_o), 0);
    check("R4", "idle ovf", longint'(ovf_o), 0);
    rst_ni = 1'b1;

    drive(32'h12345678, 32'h11111111, 1'b0, 1'b0, "R1");
    drive(32'h00000009, 32'h00000001, 1'b0, 1'b0, "R8");
    drive(32'h00000090, 32'h00000010, 1'b0, 1'b0, "R8");
    drive(32'h90909090, 32'h09090909, 1'b0, 1'b0, "R1");
    drive(32'h99999999, 32'h00000000, 1'b0, 1'b1, "R6");
    drive(32'h50505050, 32'h49494949, 1'b0, 1'b1, "R6");
    drive(32'h90909090, 32'h09090909, 1'b0, 1'b1, "R6");
    drive(32'h99999999, 32'h99999999, 1'b0, 1'b1, "R1");
    drive(32'h12345678, 32'h87654321, 1'b1, 1'b0, "R2");
    drive(32'h12345678, 32'h87654321, 1'b1, 1'b1, "R2");
    drive(32'h00000000, 32'h00000001, 1'b1, 1'b1, "R2");
    drive(32'h00000000, 32'h00000000, 1'b1, 1'b0, "R7");
    drive(32'h73920418, 32'h73920418, 1'b1, 1'b1, "R7");
    drive(32'h99999999, 32'h99999999, 1'b1, 1'b0, "R7");
    drive(32'h49999999, 32'h00000001, 1'b0, 1'b0, "R4");
    drive(32'h49999999, 32'h00000000, 1'b0, 1'b1, "R4");
    drive(32'h50000000, 32'h00000001, 1'b1, 1'b0, "R4");
    drive(32'h50000000, 32'h50000000, 1'b1, 1'b0, "R4");
    drive(32'h00000001, 32'h50000000, 1'b1, 1'b0, "R4");
    drive(32'h99999999, 32'h50000000, 1'b1, 1'b0, "R8");
    drive(32'h50000000, 32'h99999999, 1'b0, 1'b0, "R4");

    for (int i = 0; i < 400; i++)
      drive(rand_bcd(), rand_bcd(), 1'b0, 1'($urandom_range(1)), "R1");
    for (int i = 0; i < 400; i++)
      drive(rand_bcd(), rand_bcd(), 1'b1, 1'($urandom_range(1)), "R2");

    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule